// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns one command word into the pin-level cycles of a raw 8-bit NAND flash bus. A command picks one of three operations: push bytes to the device, pull bytes from it, or wait for the device to report ready. For transfers, the command also says whether the bytes form a command/address string or a data stream. The same word carries the target chip and the number of bytes. Three programmable cycle counts set the shape of every strobe: an address setup before the strobe, a data setup while the strobe is low, and a data hold after the strobe rises.

Write bytes come from the host on a simple stream. The sequencer pulses `wr_next` when it has finished with each byte. Read bytes are returned on `rd_data`, qualified by `rd_valid`. A read byte is latched either when a sample pulse arrives from an external delay block, or, when that delay block is disabled, in the last cycle the read strobe is low. The wait operation watches the selected chip's ready/busy line and gives up after a programmable limit. A chip-select lock option keeps the chip enabled between operations. A new command is taken only while the sequencer is idle.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset, every `nand_ce_n` bit, `nand_we_n` and `nand_re_n` are 1, `nand_cle`, `nand_ale`, `nand_dq_oe` and `op_done` are 0, and `seq_idle` is 1.
- R2: A command is accepted on a clock edge where `cmd_start` is 1 and `seq_idle` is 1. `cmd_start` while busy has no effect. Mode code 3 has no effect: no strobe, no `op_done`, and `seq_idle` stays 1.
- R3: Mode code 0 (write) moves each byte the same way. First `nand_we_n` stays high for `cfg_addr_setup` cycles; a value of 0 skips this step. Then `nand_we_n` is low for the data-setup count. Then it is high for the data-hold count. `nand_dq_oe` is 1 and `nand_dq_out` carries `wr_data` for the whole byte. `wr_next` pulses once, in the last hold cycle.
- R4: A data-setup or data-hold field of 0 means 2^TIME_W cycles (256 by default), not zero cycles.
- R5: With `cmd_cle`=1, the first byte of the operation has `nand_cle`=1 and every later byte has `nand_ale`=1. With `cmd_cle`=0, both stay 0.
- R6: Mode code 1 (read) drives `nand_re_n` with the same setup, low and hold timing as a write. With `cfg_dly_en`=0, `nand_dq_in` is latched in the last cycle `nand_re_n` is low. `rd_valid` pulses in the following cycle with that byte on `rd_data`.
- R7: With `cfg_dly_en`=1, a read byte is latched on the first cycle that `sample_strobe` is 1 while the strobe is low or in hold. If no sample pulse comes, the byte is latched in the last hold cycle.
- R8: An operation moves exactly `cmd_count` bytes. The cycles from acceptance to `op_done` total `cmd_count`×(address setup + data setup + data hold). A count of 0 gives `op_done` in the cycle right after acceptance, with no strobe.
- R9: `op_done` is a single-cycle pulse at the end of each operation.
- R10: Mode code 2 (wait) ends with `op_done` in the cycle after the selected `nand_rb_n` bit is seen at 1. If that bit is seen at 0 for `cfg_busy_limit`+1 consecutive cycles, the operation ends with `op_timeout` pulsing together with `op_done`.
- R11: The chip given by `cmd_cs` has its `nand_ce_n` bit low for the whole operation. With `cmd_lock`=1, that bit stays low after `op_done` until the next command. With `cmd_lock`=0, all bits return high.
- R12: `nand_we_n` and `nand_re_n` are never low together. `nand_cle` and `nand_ale` are never high together. At most one `nand_ce_n` bit is low at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start request for the command on the cmd_* inputs |
| cmd_mode | input | 2 | 0 write, 1 read, 2 wait for ready, 3 reserved |
| cmd_cle | input | 1 | 1: command/address string, 0: data |
| cmd_cs | input | CS_W | Target chip |
| cmd_lock | input | 1 | Keep the chip enabled after the operation |
| cmd_count | input | CNT_W | Bytes to move |
| cfg_addr_setup | input | TIME_W | Address setup cycles (0 = none) |
| cfg_data_setup | input | TIME_W | Strobe low cycles (0 = 2^TIME_W) |
| cfg_data_hold | input | TIME_W | Hold cycles after strobe (0 = 2^TIME_W) |
| cfg_busy_limit | input | LIM_W | Busy limit for the wait operation |
| cfg_dly_en | input | 1 | Use sample_strobe for read capture |
| seq_idle | output | 1 | Ready to accept a command |
| op_done | output | 1 | End-of-operation pulse |
| op_timeout | output | 1 | Wait operation ended on the busy limit |
| wr_data | input | 8 | Current write byte |
| wr_next | output | 1 | Current write byte consumed |
| rd_data | output | 8 | Latched read byte |
| rd_valid | output | 1 | rd_data update pulse |
| sample_strobe | input | 1 | Sample pulse from the delay block |
| nand_ce_n | output | NUM_CS | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_in | input | 8 | Data bus in |
| nand_rb_n | input | NUM_CS | Ready (1) / busy (0) per chip |

## Verification
Some properties are checked by assertions on every cycle. The two strobes never overlap, the latch enables never overlap, and at most one chip is enabled. The block stays quiet on the pins while idle. A timeout always comes with a done pulse, and done never lasts two cycles. A write strobe always comes with the data bus driven, and a read byte is only returned from inside a read window.

Other behaviour only the bench scenarios can show. This covers the exact strobe widths, including the zero-means-maximum case, and the CLE-then-ALE ordering of a command string. It covers total operation latency, capture timing with and without the delay block, the busy-limit count, chip-select lock, and commands that must be ignored.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    OP_WRITE   = 2'd0,
    OP_READ    = 2'd1,
    OP_WAITRDY = 2'd2,
    OP_RSVD    = 2'd3
  } op_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ASU  = 3'd1,
    ST_STRB = 3'd2,
    ST_HOLD = 3'd3,
    ST_WAIT = 3'd4,
    ST_FIN  = 3'd5
  } seq_state_e;

endpackage

// File: rtl/nand_phase_timer.sv
// Down counter for one bus phase. Loading N makes the phase last N cycles;
// loading 0 wraps to 2^W cycles, which gives the zero-means-maximum rule.
module nand_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick_en,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val - W'(1);
    else if (tick_en && (cnt_q != '0))
      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/nand_rd_capture.sv
// Latches one read byte per strobe: on the delay block's sample pulse, or
// at the strobe's last low cycle when the delay block is off.
module nand_rd_capture #(
  parameter int DQ_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_window,
  input  logic            strb_last,
  input  logic            hold_last,
  input  logic            dly_en,
  input  logic            sample_strobe,
  input  logic [DQ_W-1:0] dq_in,
  output logic [DQ_W-1:0] rd_data,
  output logic            rd_valid
);
  logic            got_q, got_d;
  logic            cap;
  logic [DQ_W-1:0] data_q;
  logic            valid_q;

  always_comb begin
    if (dly_en)
      cap = !got_q && ((in_window && sample_strobe) || hold_last);
    else
      cap = !got_q && strb_last;
    got_d = got_q;
    if (hold_last)  got_d = 1'b0;
    else if (cap)   got_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      got_q   <= got_d;
      valid_q <= cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   data_q <= '0;
    else if (cap) data_q <= dq_in;
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;

  assert_cap_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(in_window))
    else $error("read byte returned outside a read window");
endmodule

// File: rtl/nand_ce_ctrl.sv
// Chip-enable decode with optional hold of the last chip after an operation.
module nand_ce_ctrl #(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_active,
  input  logic              op_end,
  input  logic              lock,
  input  logic [CS_W-1:0]   cs,
  output logic [NUM_CS-1:0] ce_n
);
  logic            held_q, held_d;
  logic [CS_W-1:0] held_cs_q, held_cs_d;
  logic            sel_en;
  logic [CS_W-1:0] sel_cs;

  always_comb begin
    held_d    = held_q;
    held_cs_d = held_cs_q;
    if (op_end) begin
      held_d    = lock;
      held_cs_d = cs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q    <= 1'b0;
      held_cs_q <= '0;
    end else begin
      held_q    <= held_d;
      held_cs_q <= held_cs_d;
    end
  end

  assign sel_en = op_active || held_q;
  assign sel_cs = op_active ? cs : held_cs_q;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
    assign ce_n[g] = !(sel_en && (sel_cs == CS_W'(g)));
  end
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nand_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 12,
  parameter int TIME_W = 8,
  parameter int LIM_W  = 16,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [1:0]        cmd_mode,
  input  logic              cmd_cle,
  input  logic [CS_W-1:0]   cmd_cs,
  input  logic              cmd_lock,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [TIME_W-1:0] cfg_addr_setup,
  input  logic [TIME_W-1:0] cfg_data_setup,
  input  logic [TIME_W-1:0] cfg_data_hold,
  input  logic [LIM_W-1:0]  cfg_busy_limit,
  input  logic              cfg_dly_en,
  output logic              seq_idle,
  output logic              op_done,
  output logic              op_timeout,
  input  logic [7:0]        wr_data,
  output logic              wr_next,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              sample_strobe,
  output logic [NUM_CS-1:0] nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_in,
  input  logic [NUM_CS-1:0] nand_rb_n
);
  seq_state_e        state_q, state_d;
  op_mode_e          mode_q;
  logic              cle_q, lock_q;
  logic [CS_W-1:0]   cs_q;
  logic [TIME_W-1:0] as_q, ds_q, dh_q;
  logic [LIM_W-1:0]  limit_q;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              first_q, first_d;
  logic [LIM_W-1:0]  wait_q, wait_d;
  logic              to_q, to_d;

  logic              accept;
  logic              tmr_load;
  logic [TIME_W-1:0] tmr_val;
  logic              tmr_exp;
  logic              in_byte, is_wr, is_rd, rb_sel;

  assign accept = (state_q == ST_IDLE) && cmd_start && (op_mode_e'(cmd_mode) != OP_RSVD);
  assign rb_sel = nand_rb_n[cs_q];

  // next-state logic
  always_comb begin
    state_d  = state_q;
    left_d   = left_q;
    first_d  = first_q;
    wait_d   = wait_q;
    to_d     = to_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          left_d  = cmd_count;
          first_d = 1'b1;
          wait_d  = '0;
          to_d    = 1'b0;
          if (op_mode_e'(cmd_mode) == OP_WAITRDY) begin
            state_d = ST_WAIT;
          end else if (cmd_count == '0) begin
            state_d = ST_FIN;
          end else if (cfg_addr_setup != '0) begin
            state_d  = ST_ASU;
            tmr_load = 1'b1;
            tmr_val  = cfg_addr_setup;
          end else begin
            state_d  = ST_STRB;
            tmr_load = 1'b1;
            tmr_val  = cfg_data_setup;
          end
        end
      end
      ST_ASU: begin
        if (tmr_exp) begin
          state_d  = ST_STRB;
          tmr_load = 1'b1;
          tmr_val  = ds_q;
        end
      end
      ST_STRB: begin
        if (tmr_exp) begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = dh_q;
        end
      end
      ST_HOLD: begin
        if (tmr_exp) begin
          left_d  = left_q - CNT_W'(1);
          first_d = 1'b0;
          if (left_q == CNT_W'(1)) begin
            state_d = ST_FIN;
          end else if (as_q != '0) begin
            state_d  = ST_ASU;
            tmr_load = 1'b1;
            tmr_val  = as_q;
          end else begin
            state_d  = ST_STRB;
            tmr_load = 1'b1;
            tmr_val  = ds_q;
          end
        end
      end
      ST_WAIT: begin
        if (rb_sel) begin
          state_d = ST_FIN;
        end else if (wait_q == limit_q) begin
          to_d    = 1'b1;
          state_d = ST_FIN;
        end else begin
          wait_d = wait_q + LIM_W'(1);
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // sequencing registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      first_q <= 1'b0;
      wait_q  <= '0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      first_q <= first_d;
      wait_q  <= wait_d;
      to_q    <= to_d;
    end
  end

  // command fields, enabled by acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= OP_WRITE;
      cle_q   <= 1'b0;
      lock_q  <= 1'b0;
      cs_q    <= '0;
      as_q    <= '0;
      ds_q    <= '0;
      dh_q    <= '0;
      limit_q <= '0;
    end else if (accept) begin
      mode_q  <= op_mode_e'(cmd_mode);
      cle_q   <= cmd_cle;
      lock_q  <= cmd_lock;
      cs_q    <= cmd_cs;
      as_q    <= cfg_addr_setup;
      ds_q    <= cfg_data_setup;
      dh_q    <= cfg_data_hold;
      limit_q <= cfg_busy_limit;
    end
  end

  assign in_byte = (state_q == ST_ASU) || (state_q == ST_STRB) || (state_q == ST_HOLD);
  assign is_wr   = (mode_q == OP_WRITE);
  assign is_rd   = (mode_q == OP_READ);

  nand_phase_timer #(.W(TIME_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick_en  (in_byte),
    .expired  (tmr_exp)
  );

  nand_rd_capture #(.DQ_W(8)) u_capture (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_window     (is_rd && ((state_q == ST_STRB) || (state_q == ST_HOLD))),
    .strb_last     (is_rd && (state_q == ST_STRB) && tmr_exp),
    .hold_last     (is_rd && (state_q == ST_HOLD) && tmr_exp),
    .dly_en        (cfg_dly_en),
    .sample_strobe (sample_strobe),
    .dq_in         (nand_dq_in),
    .rd_data       (rd_data),
    .rd_valid      (rd_valid)
  );

  nand_ce_ctrl #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_ce (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_active (state_q != ST_IDLE),
    .op_end    (state_q == ST_FIN),
    .lock      (lock_q),
    .cs        (cs_q),
    .ce_n      (nand_ce_n)
  );

  assign nand_we_n   = !((state_q == ST_STRB) && is_wr);
  assign nand_re_n   = !((state_q == ST_STRB) && is_rd);
  assign nand_cle    = in_byte && cle_q && first_q;
  assign nand_ale    = in_byte && cle_q && !first_q;
  assign nand_dq_oe  = in_byte && is_wr;
  assign nand_dq_out = nand_dq_oe ? wr_data : 8'h00;
  assign wr_next     = is_wr && (state_q == ST_HOLD) && tmr_exp;
  assign seq_idle    = (state_q == ST_IDLE);
  assign op_done     = (state_q == ST_FIN);
  assign op_timeout  = (state_q == ST_FIN) && to_q;

  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n))
    else $error("write and read strobes low together");
  assert_latch_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale))
    else $error("CLE and ALE high together");
  assert_ce_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n))
    else $error("more than one chip enabled");
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle |-> (nand_we_n && nand_re_n && !nand_dq_oe))
    else $error("strobe or drive while idle");
  assert_timeout_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_timeout |-> op_done)
    else $error("timeout without done");
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done)
    else $error("done longer than one cycle");
  assert_we_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe)
    else $error("write strobe with bus not driven");
endmodule

// File: tb/test_nand_strobe_seq.sv
`timescale 1ns/1ps
module test_nand_strobe_seq;
  import nand_seq_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cmd_start = 1'b0;
  logic [1:0]  cmd_mode = 2'd0;
  logic        cmd_cle = 1'b0;
  logic [1:0]  cmd_cs = 2'd0;
  logic        cmd_lock = 1'b0;
  logic [11:0] cmd_count = '0;
  logic [7:0]  cfg_addr_setup = '0, cfg_data_setup = 8'd1, cfg_data_hold = 8'd1;
  logic [15:0] cfg_busy_limit = '0;
  logic        cfg_dly_en = 1'b0;
  logic        seq_idle, op_done, op_timeout, wr_next, rd_valid;
  logic [7:0]  wr_data, rd_data, nand_dq_out;
  logic        sample_strobe = 1'b0;
  logic [3:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  dq_in_b = 8'h00;
  logic [3:0]  rb_b = 4'hF;

  nand_strobe_seq i_nand_strobe_seq (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_mode(cmd_mode),
    .cmd_cle(cmd_cle), .cmd_cs(cmd_cs), .cmd_lock(cmd_lock), .cmd_count(cmd_count),
    .cfg_addr_setup(cfg_addr_setup), .cfg_data_setup(cfg_data_setup),
    .cfg_data_hold(cfg_data_hold), .cfg_busy_limit(cfg_busy_limit),
    .cfg_dly_en(cfg_dly_en), .seq_idle(seq_idle), .op_done(op_done),
    .op_timeout(op_timeout), .wr_data(wr_data), .wr_next(wr_next),
    .rd_data(rd_data), .rd_valid(rd_valid), .sample_strobe(sample_strobe),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(dq_in_b), .nand_rb_n(rb_b)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard queues
  typedef struct packed {
    logic [7:0] data;
    logic       cle;
    logic       ale;
    logic [3:0] ce_n;
    int         low;
  } wr_item_t;
  wr_item_t wq[$];
  logic [7:0] rq[$];

  logic [7:0] wbuf [0:15];
  int wr_ptr = 0;
  assign wr_data = wbuf[wr_ptr[3:0]];

  int we_falls = 0, re_falls = 0, excl_bad = 0;

  // write monitor
  int   low_cnt = 0;
  logic prev_we = 1'b1;
  logic [7:0] m_data; logic m_cle, m_ale, m_oe; logic [3:0] m_ce;
  always @(negedge clk) begin
    if (wr_next) wr_ptr++;
    if (!nand_we_n) begin
      if (prev_we) we_falls++;
      low_cnt++;
      m_data = nand_dq_out; m_cle = nand_cle; m_ale = nand_ale;
      m_oe = nand_dq_oe; m_ce = nand_ce_n;
    end else if (!prev_we) begin
      if (wq.size() == 0) begin
        chk(1'b0, "R2", "unexpected write strobe", 1, 0);
      end else begin
        wr_item_t e;
        e = wq.pop_front();
        chk(low_cnt == e.low, "R3", "write strobe low cycles", low_cnt, e.low);
        chk(m_data == e.data && m_oe, "R3", "write byte on bus", m_data, e.data);
        chk(m_cle == e.cle && m_ale == e.ale, "R5", "latch enables {cle,ale}",
            {m_cle, m_ale}, {e.cle, e.ale});
        chk(m_ce == e.ce_n, "R11", "chip enable during write", m_ce, e.ce_n);
      end
      low_cnt = 0;
    end
    prev_we = nand_we_n;
    if ((!nand_we_n && !nand_re_n) || (nand_cle && nand_ale) ||
        ($countones(~nand_ce_n) > 1)) excl_bad++;
  end

  // read monitor
  always @(negedge clk) begin
    if (rd_valid) begin
      if (rq.size() == 0) chk(1'b0, "R6", "unexpected read byte", rd_data, 0);
      else begin
        logic [7:0] e;
        e = rq.pop_front();
        chk(rd_data == e, "R6", "read byte value", rd_data, e);
      end
    end
  end

  // NAND data model: 0 hold byte from strobe fall, 1 byte only with sample pulse
  int rd_model = 0, re_idx = 0, ph = 100;
  logic [7:0] rd_base = 8'h00, cur = 8'h00;
  logic prev_re = 1'b1;
  always @(negedge clk) begin
    if (prev_re && !nand_re_n) begin
      re_falls++;
      ph  = 0;
      cur = rd_base + 8'(re_idx);
      re_idx++;
      dq_in_b = (rd_model == 1) ? 8'h5A : cur;
    end else if (ph < 100) ph++;
    if (rd_model == 1 && ph != 0) begin
      if (ph == 1) begin dq_in_b = cur; sample_strobe = 1'b1; end
      else begin dq_in_b = 8'h5A; sample_strobe = 1'b0; end
    end
    prev_re = nand_re_n;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic int eff(input int v);
    return (v == 0) ? 256 : v;
  endfunction

  task automatic issue(input int mode, input bit cle, input int cs, input bit lock,
                       input int cnt, input int as, input int ds, input int dh,
                       input int lim);
    @(negedge clk);
    cmd_mode = 2'(mode); cmd_cle = cle; cmd_cs = 2'(cs); cmd_lock = lock;
    cmd_count = 12'(cnt); cfg_addr_setup = 8'(as); cfg_data_setup = 8'(ds);
    cfg_data_hold = 8'(dh); cfg_busy_limit = 16'(lim);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  int   lat;
  logic to_seen;
  task automatic wait_done(input int rel, input int cs);
    lat = 0;
    while (!op_done && lat < 5000) begin
      if (lat == rel) rb_b[cs] = 1'b1;
      lat++;
      @(negedge clk);
    end
    to_seen = op_timeout;
    @(negedge clk);
    chk(!op_done, "R9", "done single cycle", op_done, 0);
  endtask

  task automatic run_write(input bit cle, input int cs, input bit lock, input int cnt,
                           input int as, input int ds, input int dh, input int base);
    wr_item_t it;
    wr_ptr = 0;
    for (int i = 0; i < 16; i++) wbuf[i] = 8'(base + 37 * i);
    for (int i = 0; i < cnt; i++) begin
      it.data = 8'(base + 37 * i);
      it.cle  = cle && (i == 0);
      it.ale  = cle && (i != 0);
      it.ce_n = ~(4'b0001 << cs);
      it.low  = eff(ds);
      wq.push_back(it);
    end
    issue(0, cle, cs, lock, cnt, as, ds, dh, 0);
    wait_done(-1, 0);
    chk(lat == cnt * (as + eff(ds) + eff(dh)), "R8", "write latency",
        lat, cnt * (as + eff(ds) + eff(dh)));
    chk(wq.size() == 0, "R8", "write bytes outstanding", wq.size(), 0);
    chk(wr_ptr == cnt, "R3", "wr_next pulses", wr_ptr, cnt);
  endtask

  task automatic run_read(input int cs, input bit lock, input int cnt, input int as,
                          input int ds, input int dh, input bit dly, input int model,
                          input int base);
    rd_model = model; cfg_dly_en = dly; rd_base = 8'(base); re_idx = 0;
    for (int i = 0; i < cnt; i++) rq.push_back(8'(base + i));
    issue(1, 1'b0, cs, lock, cnt, as, ds, dh, 0);
    wait_done(-1, 0);
    chk(lat == cnt * (as + eff(ds) + eff(dh)), "R6", "read latency",
        lat, cnt * (as + eff(ds) + eff(dh)));
    chk(rq.size() == 0, dly ? "R7" : "R6", "read bytes outstanding", rq.size(), 0);
    rd_model = 0; cfg_dly_en = 1'b0;
  endtask

  initial begin
    int wf;
    for (int i = 0; i < 16; i++) wbuf[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(nand_ce_n == 4'hF && nand_we_n && nand_re_n && !nand_cle && !nand_ale &&
        !nand_dq_oe && seq_idle && !op_done, "R1", "reset pin state",
        {nand_ce_n, nand_we_n, nand_re_n}, 6'h3F);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R5 command string, R11 without lock
    run_write(1'b1, 0, 1'b0, 3, 2, 3, 1, 8'h70);
    chk(nand_ce_n == 4'hF, "R11", "chip released without lock", nand_ce_n, 4'hF);
    // data class, no address setup, lock chip 2
    run_write(1'b0, 2, 1'b1, 4, 0, 1, 2, 8'h11);
    chk(nand_ce_n == 4'b1011, "R11", "chip held with lock", nand_ce_n, 4'b1011);
    // R4 zero fields mean maximum
    run_write(1'b0, 1, 1'b0, 1, 1, 0, 0, 8'hC3);
    // R8 zero count
    wf = we_falls;
    run_write(1'b0, 0, 1'b0, 0, 2, 2, 2, 8'h00);
    chk(we_falls == wf, "R8", "no strobe for zero count", we_falls, wf);

    // R6 read without delay block
    run_read(1, 1'b0, 4, 1, 2, 1, 1'b0, 0, 8'h40);
    // R7 read with sample pulse (bus valid only around the pulse)
    run_read(3, 1'b0, 3, 0, 4, 2, 1'b1, 1, 8'h90);
    // R7 read with delay on but no pulse: fallback at hold end
    run_read(0, 1'b0, 2, 0, 3, 2, 1'b1, 0, 8'hE0);

    // R10 wait with device ready at once
    rb_b = 4'hF;
    issue(2, 1'b0, 2, 1'b0, 0, 0, 1, 1, 7);
    wait_done(-1, 2);
    chk(lat == 1 && !to_seen, "R10", "ready wait latency", lat, 1);
    // R10 wait released after 5 cycles
    rb_b[1] = 1'b0;
    issue(2, 1'b0, 1, 1'b0, 0, 0, 1, 1, 40);
    wait_done(5, 1);
    chk(lat == 6 && !to_seen, "R10", "released wait latency", lat, 6);
    // R10 timeout, with R2 command issued while busy
    rb_b[3] = 1'b0;
    wf = we_falls;
    issue(2, 1'b0, 3, 1'b0, 0, 0, 1, 1, 9);
    lat = 0;
    while (!op_done && lat < 5000) begin
      if (lat == 3) begin
        cmd_mode = 2'd0; cmd_count = 12'd2; cfg_data_setup = 8'd1; cmd_start = 1'b1;
      end else cmd_start = 1'b0;
      lat++;
      @(negedge clk);
    end
    cmd_start = 1'b0;
    chk(op_timeout == 1'b1, "R10", "timeout flag", op_timeout, 1);
    chk(lat == 10, "R10", "timeout latency", lat, 10);
    repeat (3) @(negedge clk);
    chk(we_falls == wf && seq_idle, "R2", "command while busy ignored", we_falls, wf);
    rb_b = 4'hF;

    // R2 reserved mode ignored
    @(negedge clk);
    cmd_mode = 2'd3; cmd_count = 12'd2; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    begin
      int bad = 0;
      for (int i = 0; i < 4; i++) begin
        if (!seq_idle || op_done) bad++;
        @(negedge clk);
      end
      chk(bad == 0 && we_falls == wf, "R2", "reserved mode ignored", bad, 0);
    end

    chk(excl_bad == 0, "R12", "exclusive strobes/enables", excl_bad, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule